// File: doc/BRIEF.md
# Two-way set-associative cache controller

This block sits between a processor port and a slow backing memory and keeps a small on-chip copy of recently used memory blocks. The cache holds 1024 words as 8 lines of 128 words. The lines form 4 sets of 2 ways, and the set is the block number modulo 4. Each set keeps one least-recently-used bit to choose which way to replace.

A processor request presents a word address and holds it until `req_ready_o` rises. A request that hits completes in the same cycle and returns the word. A request that misses raises a one-cycle miss indication. The controller then fetches the whole block from memory as a counted burst of 4-word beats. The memory may take longer for the first beat than for the beats that follow. The block is written into the victim way, and the held request then completes as a hit. Two counters report how many requests hit and how many missed, so a reference model of a block trace can be checked against them.

Top module: `cache_ctrl_2way`

## Requirements
- R1: After reset every line is invalid, both counters read zero, and `req_ready_o` and `mem_req_o` are low. The first access to any block is a miss.
- R2: A word address splits into offset = bits [6:0], set = bits [8:7] (block id modulo 4) and tag = bits [15:9]. The block id is bits [15:7]. The word returned is the one at that offset within its block.
- R3: When the controller is idle and a request hits, `rsp_hit_o` and `req_ready_o` are high in that same cycle and `rsp_data_o` carries the word. `hit_count_o` rises by one after the clock edge. `rsp_hit_o` and `rsp_miss_o` are never high together.
- R4: When the controller is idle and a request misses, `rsp_miss_o` is high for that cycle and `req_ready_o` stays low. `miss_count_o` rises by one. From the next cycle `mem_req_o` is high and `mem_blk_o` carries the block id.
- R5: A refill accepts exactly 32 beats, whatever the gaps between them. Beat n carries block words 4n to 4n+3, and word k of the beat is in bits [32k+31:32k]. `mem_req_o` falls in the cycle after the 32nd beat is taken.
- R6: While `mem_req_o` is high, `req_ready_o` stays low. In the cycle `mem_req_o` falls, the held request completes as a hit with the refilled word. This completion does not change `hit_count_o`.
- R7: On a miss the victim is an invalid way if the set has one, with way 0 taken before way 1. Otherwise the victim is the least recently used way.
- R8: Each set's LRU bit is updated on every hit and every fill so that it points at the way not just used.
- R9: Two blocks that map to the same set coexist. A third block in that set evicts only the least recently used of the two. Other sets are not affected.
- R10: Over a trace of block accesses starting from reset, the hit/miss outcome of each access and the final counter values match a two-way LRU reference model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present, held until ready |
| req_addr_i | input | ADDR_W | Word address of the request |
| req_ready_o | output | 1 | Request completes this cycle |
| rsp_hit_o | output | 1 | Lookup hit this cycle |
| rsp_miss_o | output | 1 | Lookup missed; refill begins |
| rsp_data_o | output | DATA_W | Word read on a hit |
| mem_req_o | output | 1 | Refill burst in progress |
| mem_blk_o | output | ADDR_W-7 | Block id being fetched |
| mem_beat_valid_i | input | 1 | A 4-word beat is present |
| mem_beat_data_i | input | 4*DATA_W | Beat data, word k in slice k |
| hit_count_o | output | CNT_W | Lookups that hit |
| miss_count_o | output | CNT_W | Lookups that missed |

## Verification
The bench stresses replacement within one set. It alternates reuse of two resident blocks and then brings in a third. A design with an inverted LRU bit, or one that skips the update on a hit, evicts the block just used, so a later access misses where it should hit. It also checks that an invalid way is filled before any resident line is displaced. A design that skips this check overwrites a valid block early.

The refill uses a first beat ten cycles late and later beats two cycles apart. A beat counter that is off by one ends the burst early or late, which shows up as a wrong word or as a mismatch in the completion cycle. The long trace also exposes a design that counts the completion cycle as an extra hit.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WAYS = 2;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_FILL
  } seq_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store import cache_pkg::*; #(
  parameter int SETS  = 4,
  parameter int SET_W = 2,
  parameter int TAG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic             hit_way_o,
  output logic             victim_way_o,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic             touch_way_i,
  input  logic             fill_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic             fill_way_i,
  input  logic [TAG_W-1:0] fill_tag_i
);
  logic [SETS-1:0]  valid_q [WAYS];
  logic [TAG_W-1:0] tag_q   [WAYS][SETS];
  logic [SETS-1:0]  lru_q;
  logic [WAYS-1:0]  match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = valid_q[w][lk_set_i] && (tag_q[w][lk_set_i] == lk_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[w] <= '0;
        for (int s = 0; s < SETS; s++) tag_q[w][s] <= '0;
      end else if (fill_i && (fill_way_i == 1'(w))) begin
        valid_q[w][fill_set_i] <= 1'b1;
        tag_q[w][fill_set_i]   <= fill_tag_i;
      end
    end
  end

  assign hit_o     = |match;
  assign hit_way_o = match[1];

  // invalid ways first, way 0 before way 1, else LRU
  always_comb begin
    if (!valid_q[0][lk_set_i])      victim_way_o = 1'b0;
    else if (!valid_q[1][lk_set_i]) victim_way_o = 1'b1;
    else                            victim_way_o = lru_q[lk_set_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (fill_i)  lru_q[fill_set_i]  <= ~fill_way_i;
    else if (touch_i) lru_q[touch_set_i] <= ~touch_way_i;
  end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store import cache_pkg::*; #(
  parameter int DATA_W      = 32,
  parameter int SETS        = 4,
  parameter int BLOCK_WORDS = 128,
  parameter int BEAT_WORDS  = 4
) (
  input  logic                         clk_i,
  input  logic                         wr_i,
  input  logic                         wr_way_i,
  input  logic [$clog2(SETS)-1:0]      wr_set_i,
  input  logic [$clog2(BLOCK_WORDS/BEAT_WORDS)-1:0] wr_beat_i,
  input  logic [BEAT_WORDS*DATA_W-1:0] wr_data_i,
  input  logic                         rd_way_i,
  input  logic [$clog2(SETS)-1:0]      rd_set_i,
  input  logic [$clog2(BLOCK_WORDS)-1:0] rd_off_i,
  output logic [DATA_W-1:0]            rd_data_o
);
  localparam int BEAT_OFF_W = $clog2(BEAT_WORDS);
  localparam int DEPTH      = WAYS * SETS * BLOCK_WORDS;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      for (int k = 0; k < BEAT_WORDS; k++)
        mem_q[{wr_way_i, wr_set_i, wr_beat_i, BEAT_OFF_W'(k)}] <= wr_data_i[k*DATA_W +: DATA_W];
    end
  end

  assign rd_data_o = mem_q[{rd_way_i, rd_set_i, rd_off_i}];
endmodule

// File: rtl/cache_refill_seq.sv
module cache_refill_seq import cache_pkg::*; #(
  parameter int SET_W = 2,
  parameter int TAG_W = 7,
  parameter int BEATS = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [SET_W-1:0]         start_set_i,
  input  logic [TAG_W-1:0]         start_tag_i,
  input  logic                     start_way_i,
  input  logic                     beat_valid_i,
  output logic                     busy_o,
  output logic                     beat_wr_o,
  output logic [$clog2(BEATS)-1:0] beat_idx_o,
  output logic                     fill_o,
  output logic [SET_W-1:0]         set_o,
  output logic [TAG_W-1:0]         tag_o,
  output logic                     way_o
);
  localparam int BEAT_W = $clog2(BEATS);

  seq_state_e        state_q;
  logic [BEAT_W-1:0] cnt_q;
  logic              last_beat;

  assign busy_o     = (state_q == SEQ_FILL);
  assign beat_wr_o  = busy_o && beat_valid_i;
  assign beat_idx_o = cnt_q;
  assign last_beat  = (cnt_q == BEAT_W'(BEATS - 1));
  assign fill_o     = beat_wr_o && last_beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      set_o   <= '0;
      tag_o   <= '0;
      way_o   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_FILL;
          cnt_q   <= '0;
          set_o   <= start_set_i;
          tag_o   <= start_tag_i;
          way_o   <= start_way_i;
        end
        SEQ_FILL: if (beat_valid_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_beat) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_ctrl_2way.sv
module cache_ctrl_2way import cache_pkg::*; #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 16,
  parameter int CACHE_WORDS = 1024,
  parameter int BLOCK_WORDS = 128,
  parameter int BEAT_WORDS  = 4,
  parameter int CNT_W       = 16
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 req_valid_i,
  input  logic [ADDR_W-1:0]                    req_addr_i,
  output logic                                 req_ready_o,
  output logic                                 rsp_hit_o,
  output logic                                 rsp_miss_o,
  output logic [DATA_W-1:0]                    rsp_data_o,
  output logic                                 mem_req_o,
  output logic [ADDR_W-$clog2(BLOCK_WORDS)-1:0] mem_blk_o,
  input  logic                                 mem_beat_valid_i,
  input  logic [BEAT_WORDS*DATA_W-1:0]         mem_beat_data_i,
  output logic [CNT_W-1:0]                     hit_count_o,
  output logic [CNT_W-1:0]                     miss_count_o
);
  localparam int LINES  = CACHE_WORDS / BLOCK_WORDS;
  localparam int SETS   = LINES / WAYS;
  localparam int OFF_W  = $clog2(BLOCK_WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int BEATS  = BLOCK_WORDS / BEAT_WORDS;
  localparam int BEAT_W = $clog2(BEATS);

  logic [OFF_W-1:0]  lk_off;
  logic [SET_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic              tag_hit, hit_way, victim_way;
  logic              seq_busy, beat_wr, fill;
  logic [BEAT_W-1:0] beat_idx;
  logic [SET_W-1:0]  fill_set;
  logic [TAG_W-1:0]  fill_tag;
  logic              fill_way;
  logic              lookup, hit_now, miss_now;
  logic              resume_q;
  logic [CNT_W-1:0]  hit_cnt_q, miss_cnt_q;

  assign lk_off = req_addr_i[OFF_W-1:0];
  assign lk_set = req_addr_i[OFF_W +: SET_W];
  assign lk_tag = req_addr_i[ADDR_W-1 -: TAG_W];

  assign lookup   = req_valid_i && !seq_busy;
  assign hit_now  = lookup && tag_hit;
  assign miss_now = lookup && !tag_hit;

  cache_tag_store #(
    .SETS (SETS),
    .SET_W(SET_W),
    .TAG_W(TAG_W)
  ) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_set_i    (lk_set),
    .lk_tag_i    (lk_tag),
    .hit_o       (tag_hit),
    .hit_way_o   (hit_way),
    .victim_way_o(victim_way),
    .touch_i     (hit_now),
    .touch_set_i (lk_set),
    .touch_way_i (hit_way),
    .fill_i      (fill),
    .fill_set_i  (fill_set),
    .fill_way_i  (fill_way),
    .fill_tag_i  (fill_tag)
  );

  cache_refill_seq #(
    .SET_W(SET_W),
    .TAG_W(TAG_W),
    .BEATS(BEATS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (miss_now),
    .start_set_i (lk_set),
    .start_tag_i (lk_tag),
    .start_way_i (victim_way),
    .beat_valid_i(mem_beat_valid_i),
    .busy_o      (seq_busy),
    .beat_wr_o   (beat_wr),
    .beat_idx_o  (beat_idx),
    .fill_o      (fill),
    .set_o       (fill_set),
    .tag_o       (fill_tag),
    .way_o       (fill_way)
  );

  cache_data_store #(
    .DATA_W     (DATA_W),
    .SETS       (SETS),
    .BLOCK_WORDS(BLOCK_WORDS),
    .BEAT_WORDS (BEAT_WORDS)
  ) u_data (
    .clk_i    (clk_i),
    .wr_i     (beat_wr),
    .wr_way_i (fill_way),
    .wr_set_i (fill_set),
    .wr_beat_i(beat_idx),
    .wr_data_i(mem_beat_data_i),
    .rd_way_i (hit_way),
    .rd_set_i (lk_set),
    .rd_off_i (lk_off),
    .rd_data_o(rsp_data_o)
  );

  // completion after refill is not a fresh hit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resume_q   <= 1'b0;
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
    end else begin
      if (fill)         resume_q <= 1'b1;
      else if (hit_now) resume_q <= 1'b0;
      if (hit_now && !resume_q) hit_cnt_q  <= hit_cnt_q + 1'b1;
      if (miss_now)             miss_cnt_q <= miss_cnt_q + 1'b1;
    end
  end

  assign req_ready_o  = hit_now;
  assign rsp_hit_o    = hit_now;
  assign rsp_miss_o   = miss_now;
  assign mem_req_o    = seq_busy;
  assign mem_blk_o    = {fill_tag, fill_set};
  assign hit_count_o  = hit_cnt_q;
  assign miss_count_o = miss_cnt_q;
endmodule

// File: rtl/cache_ctrl_2way_chk.sv
module cache_ctrl_2way_chk #(
  parameter int BEATS = 32,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_hit_o,
  input logic             rsp_miss_o,
  input logic             mem_req_o,
  input logic             mem_beat_valid_i,
  input logic [CNT_W-1:0] hit_count_o,
  input logic [CNT_W-1:0] miss_count_o
);
  localparam int BC_W = $clog2(BEATS) + 1;

  logic [BC_W-1:0] beats_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           beats_seen <= '0;
    else if (rsp_miss_o)                   beats_seen <= '0;
    else if (mem_req_o && mem_beat_valid_i) beats_seen <= beats_seen + 1'b1;
  end

  p_hit_miss_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_hit_o && rsp_miss_o));

  p_ready_with_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> rsp_hit_o);

  p_miss_opens_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |=> mem_req_o);

  p_miss_counted_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |=> (miss_count_o == $past(miss_count_o) + 1'b1));

  p_fill_beats_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_req_o) |-> (beats_seen == BC_W'(BEATS)));

  p_fill_blocks_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (!req_ready_o && !rsp_miss_o));

  p_fill_completes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_req_o) && req_valid_i) |-> req_ready_o);

  p_resume_not_counted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_req_o) && req_valid_i) |=> (hit_count_o == $past(hit_count_o)));
endmodule

bind cache_ctrl_2way cache_ctrl_2way_chk #(
  .BEATS(BEATS),
  .CNT_W(CNT_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .rsp_hit_o       (rsp_hit_o),
  .rsp_miss_o      (rsp_miss_o),
  .mem_req_o       (mem_req_o),
  .mem_beat_valid_i(mem_beat_valid_i),
  .hit_count_o     (hit_count_o),
  .miss_count_o    (miss_count_o)
);

// File: tb/cache_ctrl_2way_tb_top.sv
module cache_ctrl_2way_tb_top;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 16;
  localparam int BEAT_WORDS = 4;
  localparam int BEATS      = 32;
  localparam int BLK_W      = ADDR_W - 7;
  localparam int CNT_W      = 16;
  localparam int FIRST_LAT  = 10;
  localparam int NEXT_LAT   = 2;

  logic                         clk = 1'b0;
  logic                         rst_n;
  logic                         req_valid;
  logic [ADDR_W-1:0]            req_addr;
  logic                         req_ready_o, rsp_hit_o, rsp_miss_o, mem_req_o;
  logic [DATA_W-1:0]            rsp_data_o;
  logic [BLK_W-1:0]             mem_blk_o;
  logic                         mem_beat_valid;
  logic [BEAT_WORDS*DATA_W-1:0] mem_beat_data;
  logic [CNT_W-1:0]             hit_count_o, miss_count_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int beats_sent = 0;
  int last_beat_cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cache_ctrl_2way dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .req_valid_i     (req_valid),
    .req_addr_i      (req_addr),
    .req_ready_o     (req_ready_o),
    .rsp_hit_o       (rsp_hit_o),
    .rsp_miss_o      (rsp_miss_o),
    .rsp_data_o      (rsp_data_o),
    .mem_req_o       (mem_req_o),
    .mem_blk_o       (mem_blk_o),
    .mem_beat_valid_i(mem_beat_valid),
    .mem_beat_data_i (mem_beat_data),
    .hit_count_o     (hit_count_o),
    .miss_count_o    (miss_count_o)
  );

  function automatic logic [31:0] pattern(input int blk, input int word);
    return 32'hA000_0000 | (32'(blk) << 16) | 32'(word);
  endfunction

  // reference model: 4 sets x 2 ways, one LRU bit per set
  int  m_tag [4][2];
  bit  m_val [4][2];
  bit  m_lru [4];

  function automatic void model_clear();
    for (int s = 0; s < 4; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_val[s][w] = 0; m_tag[s][w] = 0; end
    end
  endfunction

  function automatic bit model_access(input int blk);
    int s = blk % 4;
    int t = blk / 4;
    int v;
    for (int w = 0; w < 2; w++)
      if (m_val[s][w] && m_tag[s][w] == t) begin
        m_lru[s] = (w == 0);
        return 1;
      end
    if (!m_val[s][0])      v = 0;
    else if (!m_val[s][1]) v = 1;
    else                   v = m_lru[s] ? 1 : 0;
    m_val[s][v] = 1;
    m_tag[s][v] = t;
    m_lru[s] = (v == 0);
    return 0;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory side: first beat late, later beats closer
  initial begin
    int blk;
    mem_beat_valid = 1'b0;
    mem_beat_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_o) begin
        blk = int'(mem_blk_o);
        beats_sent = 0;
        for (int b = 0; b < BEATS; b++) begin
          repeat (((b == 0) ? FIRST_LAT : NEXT_LAT) - 1) @(negedge clk);
          mem_beat_valid = 1'b1;
          for (int k = 0; k < BEAT_WORDS; k++)
            mem_beat_data[k*DATA_W +: DATA_W] = pattern(blk, b*BEAT_WORDS + k);
          @(negedge clk);
          mem_beat_valid = 1'b0;
          last_beat_cyc = cyc;
          beats_sent++;
        end
      end
    end
  end

  task automatic do_reset();
    req_valid = 1'b0;
    req_addr  = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input bit exp_hit, input string req);
    int h0 = int'(hit_count_o);
    int m0 = int'(miss_count_o);
    int blk = int'(a >> 7);
    int off = int'(a & 16'h7F);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    chk(req, $sformatf("hit flag @%0h", a), longint'(rsp_hit_o), longint'(exp_hit));
    if (exp_hit) begin
      chk("R3", "ready on hit", longint'(req_ready_o), 1);
      chk("R2", $sformatf("hit data @%0h", a), longint'(rsp_data_o), longint'(pattern(blk, off)));
      @(posedge clk); #1;
      chk("R3", "hit count step", longint'(hit_count_o), longint'(h0 + 1));
    end else begin
      chk("R4", "miss pulse", longint'(rsp_miss_o), 1);
      chk("R4", "ready low on miss", longint'(req_ready_o), 0);
      @(negedge clk); #1;
      chk("R4", "mem_req raised", longint'(mem_req_o), 1);
      chk("R4", "block id", longint'(mem_blk_o), longint'(blk));
      chk("R4", "miss count step", longint'(miss_count_o), longint'(m0 + 1));
      while (!req_ready_o) begin @(negedge clk); #1; end
      chk("R5", "beats taken", longint'(beats_sent), BEATS);
      chk("R5", "burst end cycle", longint'(cyc), longint'(last_beat_cyc));
      chk("R6", "mem_req low at completion", longint'(mem_req_o), 0);
      chk("R6", "completion as hit", longint'(rsp_hit_o), 1);
      chk("R6", $sformatf("refill data @%0h", a), longint'(rsp_data_o), longint'(pattern(blk, off)));
      @(posedge clk); #1;
      chk("R6", "completion not counted", longint'(hit_count_o), longint'(h0));
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1", "hit count", longint'(hit_count_o), 0);
    chk("R1", "miss count", longint'(miss_count_o), 0);
    chk("R1", "ready idle", longint'(req_ready_o), 0);
    chk("R1", "mem_req idle", longint'(mem_req_o), 0);
  endtask

  task automatic t_basic();
    access(16'h0005, 1'b0, "R1");
    access(16'h007F, 1'b1, "R3");
    access(16'h0040, 1'b1, "R2");
  endtask

  // set 0 holds blocks 0 and 4, block 8 forces LRU eviction
  task automatic t_ways();
    access(16'h0083, 1'b0, "R1");
    access(16'h0200, 1'b0, "R7");
    access(16'h0010, 1'b1, "R7");
    access(16'h027F, 1'b1, "R9");
    access(16'h0011, 1'b1, "R8");
    access(16'h0400, 1'b0, "R9");
    access(16'h0012, 1'b1, "R8");
    access(16'h0201, 1'b0, "R8");
    access(16'h0402, 1'b0, "R9");
    access(16'h00C0, 1'b1, "R9");
  endtask

  task automatic t_trace();
    int trace [30] = '{0, 1, 2, 3, 4, 3, 4, 5, 3, 10, 8, 7, 0, 9, 2,
                       8, 10, 7, 9, 7, 11, 13, 5, 4, 8, 13, 15, 10, 13, 12};
    int nh = 0;
    int nm = 0;
    do_reset();
    foreach (trace[i]) begin
      bit e = model_access(trace[i]);
      if (e) nh++; else nm++;
      access(16'(trace[i] * 128 + (i * 7) % 128), e, "R10");
    end
    #1;
    chk("R10", "trace hits", longint'(hit_count_o), longint'(nh));
    chk("R10", "trace misses", longint'(miss_count_o), longint'(nm));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_ways();
    t_trace();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule